// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error tallies of a CAN node, one for transmission and one for reception, and turns them into the node's confinement state: error-active, error-passive or bus-off. The protocol engine drives single-cycle event strobes for errors and successes. The unit answers with the counter values, the state, a warning flag, the kind of error flag the engine should emit, a hold-off request after transmissions in the passive state, and a bus-off indication.

Leaving bus-off requires 128 runs of 11 recessive bits on the sampled bus. The run count starts on its own when automatic recovery is enabled. Otherwise the software must raise initialisation mode and then drop it. The engine reports each sampled bit with a one-cycle `bit_tick` and its level on `bit_recessive`.

There is no data stream at this boundary. Every input is a plain control strobe or level and every output is a status level, so there is no valid/ready handshake and no back-pressure. A strobe counts in the cycle it is high.

Top module: `can_fault_confine`

## Requirements
- R1: `ev_tx_err` adds 8 to the transmit count. `ev_tx_ok` subtracts 1, but never below 0. When both arrive in the same cycle, only the addition applies. The count changes on the clock edge that samples the strobe.
- R2: `ev_rx_dom_err` adds 8 to the receive count and `ev_rx_err` adds 1. When both are present, only the 8 applies. `ev_rx_ok` subtracts 1, but never below 0. Any increment takes precedence over the decrement. The receive count saturates at 255.
- R3: `fc_state` encodes 0 = error-active (both counts at most 127), 1 = error-passive (either count at least 128, not bus-off) and 2 = bus-off. `flag_passive` is 1 whenever `fc_state` is not 0.
- R4: The node enters bus-off when the internal transmit count exceeds 255. While it is in bus-off, `bus_off` is 1 and `tx_count` reads 255.
- R5: While the node is in bus-off, all five event strobes are ignored and neither count changes.
- R6: `warn` is 1 exactly when either exposed count is at least 96.
- R7: Once recovery is armed, the unit counts runs of 11 recessive `bit_tick`s. A dominant tick restarts only the current run. The clock edge that samples the 1408th qualifying tick (run 128, bit 11) clears both counts and returns the state to 0. With `auto_recover` high, recovery arms one cycle after bus-off is entered.
- R8: With `auto_recover` low, the unit ignores recessive ticks in bus-off until `init_req` has been seen high and then low. Recovery arms on the edge that samples `init_req` low, and it counts ticks from the next cycle.
- R9: An `ev_tx_ok` or `ev_tx_err` that arrives while `fc_state` is 1 raises `tx_hold` from the next cycle. `tx_hold` stays high for 8 `bit_tick`s and then falls. A new trigger reloads the 8-tick count. Entering bus-off clears the hold.
- R10: After reset, both counts are 0, `fc_state` is 0, and `warn`, `flag_passive`, `tx_hold` and `bus_off` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_tx_err | input | 1 | Transmit error strobe |
| ev_rx_err | input | 1 | Receive error strobe (+1) |
| ev_rx_dom_err | input | 1 | Receive dominant-bit error strobe (+8) |
| ev_tx_ok | input | 1 | Successful transmission strobe |
| ev_rx_ok | input | 1 | Successful reception strobe |
| bit_tick | input | 1 | One cycle per sampled bus bit |
| bit_recessive | input | 1 | Level of the sampled bit, 1 = recessive |
| auto_recover | input | 1 | Arms recovery automatically on bus-off |
| init_req | input | 1 | Initialisation-mode request |
| tx_count | output | 8 | Exposed transmit count (255 in bus-off) |
| rx_count | output | 8 | Receive count |
| fc_state | output | 2 | Confinement state code |
| warn | output | 1 | Either count at least 96 |
| flag_passive | output | 1 | Emit passive (recessive) error flags |
| tx_hold | output | 1 | Suspend next transmission |
| bus_off | output | 1 | Node is in bus-off |

## Verification
Two pairs of functions can land in the same cycle. The first pair is an increment and a decrement strobe on one counter, which the priority rule settles. The second pair is a hold-off trigger and a bit tick, where the reload must beat the decrement. Directed cycles drive each pair together on purpose. The constrained-random phase also raises all strobes and ticks independently, so overlaps happen often, including near zero, near saturation and across bus-off entry and recovery. Every cycle, each output is compared with a bench model that applies the priority rules written in the requirements.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters #(
  parameter int CNT_W       = 8,
  parameter int TX_STEP     = 8,
  parameter int RX_DOM_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             rx_dom_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             recov_done,
  output logic [CNT_W:0]   tx_raw,
  output logic [CNT_W-1:0] rx_val,
  output logic             in_bus_off
);
  localparam int TXW = CNT_W + 1;
  localparam logic [TXW-1:0]   TX_INC  = TXW'(TX_STEP);
  localparam logic [TXW-1:0]   RX_BIG  = TXW'(RX_DOM_STEP);
  localparam logic [CNT_W-1:0] RX_TOP  = {CNT_W{1'b1}};

  logic [TXW-1:0]   tx_q, tx_d;
  logic [CNT_W-1:0] rx_q, rx_d;
  logic [TXW-1:0]   rx_step, rx_sum;

  assign in_bus_off = tx_q[CNT_W];
  assign tx_raw     = tx_q;
  assign rx_val     = rx_q;

  // transmit tally: increment wins over decrement
  always_comb begin
    tx_d = tx_q;
    if (recov_done)               tx_d = '0;
    else if (in_bus_off)          tx_d = tx_q;
    else if (tx_err)              tx_d = tx_q + TX_INC;
    else if (tx_ok && tx_q != '0) tx_d = tx_q - 1'b1;
  end

  // receive tally: dominant-bit error outweighs plain error, saturating
  always_comb begin
    rx_step = '0;
    if (rx_dom_err)  rx_step = RX_BIG;
    else if (rx_err) rx_step = TXW'(1);
    rx_sum = {1'b0, rx_q} + rx_step;
    rx_d   = rx_q;
    if (recov_done)                rx_d = '0;
    else if (in_bus_off)           rx_d = rx_q;
    else if (rx_step != '0)        rx_d = rx_sum[CNT_W] ? RX_TOP : rx_sum[CNT_W-1:0];
    else if (rx_ok && rx_q != '0)  rx_d = rx_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assert_tx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_bus_off && tx_err) |=> (tx_q == $past(tx_q) + TX_INC));

  assert_tx_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_bus_off && tx_ok && !tx_err && tx_q == '0) |=> (tx_q == '0));

  assert_rx_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_bus_off && rx_q == RX_TOP && (rx_err || rx_dom_err)) |=> (rx_q == RX_TOP));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus_off && !recov_done) |=> ($stable(tx_q) && $stable(rx_q)));
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bus_off,
  input  logic auto_en,
  input  logic init_req,
  input  logic bit_tick,
  input  logic bit_rec,
  output logic recov_done
);
  localparam int RW = (RUN_LEN   > 1) ? $clog2(RUN_LEN)   : 1;
  localparam int SW = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [SW-1:0] SEQ_LAST = SW'(RUN_COUNT - 1);

  logic          armed_q, init_seen_q;
  logic [RW-1:0] run_q;
  logic [SW-1:0] seq_q;
  logic          rec_step, last_run, last_seq;

  assign last_run   = (run_q == RUN_LAST);
  assign last_seq   = (seq_q == SEQ_LAST);
  assign rec_step   = armed_q && bit_tick && bit_rec;
  assign recov_done = in_bus_off && rec_step && last_run && last_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      init_seen_q <= 1'b0;
      run_q       <= '0;
      seq_q       <= '0;
    end else if (!in_bus_off || recov_done) begin
      armed_q     <= 1'b0;
      init_seen_q <= 1'b0;
      run_q       <= '0;
      seq_q       <= '0;
    end else begin
      init_seen_q <= init_seen_q | init_req;
      if (auto_en || (init_seen_q && !init_req)) armed_q <= 1'b1;
      if (armed_q && bit_tick) begin
        if (!bit_rec) begin
          run_q <= '0;
        end else if (last_run) begin
          run_q <= '0;
          seq_q <= seq_q + 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assert_dom_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus_off && armed_q && bit_tick && !bit_rec) |=> (run_q == '0));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q) |-> (run_q == '0 && seq_q == '0));

  assert_run_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus_off && armed_q && bit_tick && !bit_rec) |=> (seq_q == $past(seq_q)));
endmodule

// File: rtl/fc_tx_suspend.sv
module fc_tx_suspend #(
  parameter int HOLD_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic bit_tick,
  input  logic in_bus_off,
  output logic hold
);
  localparam int HW = $clog2(HOLD_BITS + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_BITS);

  logic [HW-1:0] cnt_q;

  assign hold = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (in_bus_off)                cnt_q <= '0;
    else if (trigger)                   cnt_q <= LOAD;
    else if (bit_tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_bus_off && !trigger && bit_tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_hold_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_bus_off && trigger) |=> hold);
endmodule

// File: rtl/fc_status.sv
module fc_status
  import can_fc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int WARN_LEVEL    = 96,
  parameter int PASSIVE_LEVEL = 128
) (
  input  logic [CNT_W:0]   tx_raw,
  input  logic [CNT_W-1:0] rx_val,
  output logic [CNT_W-1:0] tx_view,
  output fc_state_e        state,
  output logic             warn,
  output logic             flag_passive
);
  localparam logic [CNT_W-1:0] WARN_TH = CNT_W'(WARN_LEVEL);
  localparam logic [CNT_W-1:0] PASS_TH = CNT_W'(PASSIVE_LEVEL);

  logic over;

  assign over    = tx_raw[CNT_W];
  assign tx_view = over ? {CNT_W{1'b1}} : tx_raw[CNT_W-1:0];

  always_comb begin
    if (over)                                   state = FC_BUSOFF;
    else if (tx_view >= PASS_TH || rx_val >= PASS_TH) state = FC_PASSIVE;
    else                                        state = FC_ACTIVE;
  end

  assign warn         = (tx_view >= WARN_TH) || (rx_val >= WARN_TH);
  assign flag_passive = (state != FC_ACTIVE);
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import can_fc_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TX_STEP       = 8,
  parameter int RX_DOM_STEP   = 8,
  parameter int WARN_LEVEL    = 96,
  parameter int PASSIVE_LEVEL = 128,
  parameter int RUN_LEN       = 11,
  parameter int RUN_COUNT     = 128,
  parameter int HOLD_BITS     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_tx_err,
  input  logic             ev_rx_err,
  input  logic             ev_rx_dom_err,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             bit_tick,
  input  logic             bit_recessive,
  input  logic             auto_recover,
  input  logic             init_req,
  output logic [CNT_W-1:0] tx_count,
  output logic [CNT_W-1:0] rx_count,
  output logic [1:0]       fc_state,
  output logic             warn,
  output logic             flag_passive,
  output logic             tx_hold,
  output logic             bus_off
);
  logic [CNT_W:0] tx_raw;
  logic           in_bo;
  logic           recov_done;
  logic           hold_trig;
  fc_state_e      state;

  fc_err_counters #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RX_DOM_STEP(RX_DOM_STEP)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tx_err(ev_tx_err), .rx_err(ev_rx_err), .rx_dom_err(ev_rx_dom_err),
    .tx_ok(ev_tx_ok), .rx_ok(ev_rx_ok), .recov_done(recov_done),
    .tx_raw(tx_raw), .rx_val(rx_count), .in_bus_off(in_bo)
  );

  fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk(clk), .rst_n(rst_n), .in_bus_off(in_bo), .auto_en(auto_recover),
    .init_req(init_req), .bit_tick(bit_tick), .bit_rec(bit_recessive),
    .recov_done(recov_done)
  );

  fc_status #(
    .CNT_W(CNT_W), .WARN_LEVEL(WARN_LEVEL), .PASSIVE_LEVEL(PASSIVE_LEVEL)
  ) u_stat (
    .tx_raw(tx_raw), .rx_val(rx_count), .tx_view(tx_count),
    .state(state), .warn(warn), .flag_passive(flag_passive)
  );

  assign hold_trig = (ev_tx_ok || ev_tx_err) && (state == FC_PASSIVE);

  fc_tx_suspend #(.HOLD_BITS(HOLD_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .trigger(hold_trig), .bit_tick(bit_tick),
    .in_bus_off(in_bo), .hold(tx_hold)
  );

  assign fc_state = state;
  assign bus_off  = in_bo;

  assert_bo_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> (tx_count == {CNT_W{1'b1}} && fc_state == 2'd2));

  assert_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done |=> (!bus_off && tx_count == '0 && rx_count == '0 && fc_state == 2'd0));

  assert_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_state == 2'd0) |-> !flag_passive);
endmodule

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_err = 0, ev_rx_err = 0, ev_rx_dom_err = 0, ev_tx_ok = 0, ev_rx_ok = 0;
  logic bit_tick = 0, bit_recessive = 1, auto_recover = 0, init_req = 0;
  logic [7:0] tx_count, rx_count;
  logic [1:0] fc_state;
  logic warn, flag_passive, tx_hold, bus_off;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done_flag = 0;

  // bench model
  int m_tx = 0, m_rx = 0, m_run = 0, m_seq = 0, m_susp = 0;
  bit m_armed = 0, m_seen = 0;

  always #5 clk = ~clk;

  can_fault_confine uut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err), .ev_rx_dom_err(ev_rx_dom_err),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .bit_tick(bit_tick),
    .bit_recessive(bit_recessive), .auto_recover(auto_recover), .init_req(init_req),
    .tx_count(tx_count), .rx_count(rx_count), .fc_state(fc_state), .warn(warn),
    .flag_passive(flag_passive), .tx_hold(tx_hold), .bus_off(bus_off)
  );

  function automatic int exp_tx_view();
    return (m_tx > 255) ? 255 : m_tx;
  endfunction

  function automatic int exp_state();
    if (m_tx > 255) return 2;
    if (m_tx >= 128 || m_rx >= 128) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cycles);
    end
  endtask

  task automatic compare_all();
    chk(int'(tx_count) == exp_tx_view(), "R1 tx_count", tx_count, exp_tx_view());
    chk(int'(rx_count) == m_rx, "R2 rx_count", rx_count, m_rx);
    chk(int'(fc_state) == exp_state(), "R3 fc_state", fc_state, exp_state());
    chk(flag_passive == (exp_state() != 0), "R3 flag_passive", flag_passive, exp_state() != 0);
    chk(bus_off == (m_tx > 255), "R4 bus_off", bus_off, m_tx > 255);
    chk(warn == (exp_tx_view() >= 96 || m_rx >= 96), "R6 warn", warn,
        exp_tx_view() >= 96 || m_rx >= 96);
    chk(tx_hold == (m_susp != 0), "R9 tx_hold", tx_hold, m_susp != 0);
  endtask

  // advance the model by one clock using the inputs currently driven
  task automatic model_step();
    bit bo, fin, trig;
    int st;
    bo   = (m_tx > 255);
    st   = exp_state();
    fin  = bo && m_armed && bit_tick && bit_recessive && m_run == 10 && m_seq == 127;
    trig = (ev_tx_ok || ev_tx_err) && st == 1;
    if (bo) m_susp = 0;
    else if (trig) m_susp = 8;
    else if (bit_tick && m_susp > 0) m_susp--;
    if (!bo || fin) begin
      m_armed = 0; m_seen = 0; m_run = 0; m_seq = 0;
    end else begin
      if (m_armed && bit_tick) begin
        if (!bit_recessive) m_run = 0;
        else if (m_run == 10) begin m_run = 0; m_seq++; end
        else m_run++;
      end
      if (auto_recover || (m_seen && !init_req)) m_armed = 1;
      m_seen = m_seen | init_req;
    end
    if (fin) begin
      m_tx = 0; m_rx = 0;
    end else if (!bo) begin
      if (ev_tx_err) m_tx += 8;
      else if (ev_tx_ok && m_tx > 0) m_tx--;
      if (ev_rx_dom_err) m_rx = (m_rx + 8 > 255) ? 255 : m_rx + 8;
      else if (ev_rx_err) m_rx = (m_rx + 1 > 255) ? 255 : m_rx + 1;
      else if (ev_rx_ok && m_rx > 0) m_rx--;
    end
  endtask

  task automatic drive(input bit te, input bit re, input bit rd, input bit to, input bit ro,
                       input bit tk, input bit rec);
    @(negedge clk);
    ev_tx_err = te; ev_rx_err = re; ev_rx_dom_err = rd; ev_tx_ok = to; ev_rx_ok = ro;
    bit_tick = tk; bit_recessive = rec;
    model_step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic rec_ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 1, 1);
  endtask

  initial begin : watchdog
    while (cycles < 190000 && !done_flag) begin
      @(posedge clk);
      cycles++;
    end
    if (!done_flag) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int seed;
    int r;
    seed = 17;
    r = $urandom(seed);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk(tx_count == 0 && rx_count == 0, "R10 counts after reset", tx_count, 0);
    chk(fc_state == 0 && !warn && !flag_passive && !tx_hold && !bus_off,
        "R10 flags after reset", {warn, flag_passive, tx_hold, bus_off}, 0);

    // R1: floor at zero, then climb to warning and passive
    drive(0, 0, 0, 1, 0, 0, 1);
    chk(tx_count == 0, "R1 no underflow", tx_count, 0);
    for (int i = 0; i < 12; i++) drive(1, 0, 0, 0, 0, 0, 1);
    chk(tx_count == 96 && warn, "R6 warn at 96", tx_count, 96);
    drive(1, 0, 0, 1, 0, 0, 1);
    chk(tx_count == 104, "R1 increment wins", tx_count, 104);
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0, 0, 1);
    chk(fc_state == 1, "R3 passive at 128", fc_state, 1);

    // R9: hold-off after own transmission in passive, reload beats tick
    drive(0, 0, 0, 1, 0, 1, 1);
    chk(tx_hold == 1, "R9 hold raised", tx_hold, 1);
    rec_ticks(7);
    chk(tx_hold == 1, "R9 hold after 7 ticks", tx_hold, 1);
    rec_ticks(1);
    chk(tx_hold == 0, "R9 hold released after 8 ticks", tx_hold, 0);

    // R2: receive counting and precedence
    drive(0, 1, 1, 0, 1, 0, 1);
    chk(rx_count == 8, "R2 dominant error outweighs", rx_count, 8);
    drive(0, 1, 0, 0, 0, 0, 1);
    chk(rx_count == 9, "R2 plain error +1", rx_count, 9);
    for (int i = 0; i < 40; i++) drive(0, 0, 1, 0, 0, 0, 1);
    chk(rx_count == 255, "R2 saturate", rx_count, 255);

    // R4: drive into bus-off
    while (m_tx <= 255) drive(1, 0, 0, 0, 0, 0, 1);
    chk(bus_off && tx_count == 255, "R4 bus-off view", tx_count, 255);
    // R5: events ignored
    drive(1, 1, 1, 1, 1, 0, 1);
    drive(0, 0, 0, 1, 1, 0, 1);
    chk(tx_count == 255 && rx_count == 255 && bus_off, "R5 frozen in bus-off", rx_count, 255);

    // R8: manual mode waits for init toggle
    auto_recover = 0;
    rec_ticks(1500);
    chk(bus_off == 1, "R8 no recovery without init toggle", bus_off, 1);
    @(negedge clk); init_req = 1; model_step(); @(posedge clk); #1; compare_all();
    rec_ticks(3);
    chk(bus_off == 1, "R8 held while init high", bus_off, 1);
    @(negedge clk); init_req = 0; model_step(); @(posedge clk); #1; compare_all();
    rec_ticks(5);
    drive(0, 0, 0, 0, 0, 1, 0);
    rec_ticks(1407);
    chk(bus_off == 1, "R7 one tick short", bus_off, 1);
    rec_ticks(1);
    chk(!bus_off && tx_count == 0 && rx_count == 0 && fc_state == 0,
        "R7 recovered after 1408", tx_count, 0);

    // R7: automatic recovery
    auto_recover = 1;
    while (m_tx <= 255) drive(1, 0, 0, 0, 0, 0, 1);
    idle(2);
    rec_ticks(1407);
    chk(bus_off == 1, "R7 auto one tick short", bus_off, 1);
    rec_ticks(1);
    chk(bus_off == 0 && fc_state == 0, "R7 auto recovered", fc_state, 0);

    // constrained random phase
    for (int i = 0; i < 40000; i++) begin
      drive(($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 12) == 0,
            ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
            ($urandom % 25) != 0);
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule